// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between one processor and the external interrupt source controller. It keeps the processor's current priority threshold, a request priority used to raise an inter-processor interrupt to this processor, a single pending source number with its priority, and a flag that records whether an offer was declined. From these it drives one interrupt line to the processor. All priorities are 8-bit, and a numerically lower value is more favored.

The processor talks to the block through a valid/opcode/data command port. There are four commands: accept the pending interrupt, write the threshold, write the inter-processor request priority, and end-of-interrupt. The source controller offers new interrupts on a separate port. Whenever a source number loses its place, the block reports it on a reject strobe so that the controller can present it again. When a declined offer may now fit, the block pulses a resend strobe. Each command or offer completes in one clock. The strobes and the accept response are registered and appear one cycle later.

Top module: `irq_presenter`

## Requirements
- R1: Priorities are unsigned and lower is more favored. A pending priority of 0xFF means nothing is pending. `irq_out` is high exactly when the pending source number is nonzero and its priority is strictly below the threshold.
- R2: After reset, the threshold is 0x00, the request priority is 0xFF, nothing is pending and the declined flag is clear. All strobes and `irq_out` are low.
- R3: Accept (opcode 0) returns `{threshold[7:0], pending_source[23:0]}` on `rsp_data` with `rsp_valid` one cycle later. If a source was pending, the threshold takes the pending priority, the pending priority becomes 0xFF and the source number is cleared. Otherwise nothing changes.
- R4: An offer with no command in the same cycle is taken when its priority is below both the threshold and the pending priority, and it displaces the current pending source as a reject. Any other offer is declined and sets the declined flag.
- R5: Request-priority write (opcode 2, value in data[7:0]) stores the value. If the value is below the threshold and no greater than the pending priority, the IPI source (number 2) becomes pending at that priority and the displaced source is rejected.
- R6: A request-priority write whose value is above both the old request priority and the threshold emits the declined flag as a resend strobe and then clears the flag.
- R7: A threshold write (opcode 1, data[7:0]) below the current threshold loads it. If the new value is no greater than the pending priority, the pending source is rejected, cleared, and its priority set to 0xFF.
- R8: A threshold write above the current threshold loads it. If the request priority is below the new threshold and no greater than the pending priority, the IPI becomes pending at the request priority. The declined flag is emitted as a resend strobe and cleared.
- R9: A threshold write equal to the current threshold changes nothing and emits no strobe.
- R10: End-of-interrupt (opcode 3) performs the R8 operation with data[31:24] as the new threshold. If data[23:0] is not the IPI number and `eoi_src_active` is high, data[23:0] is reported as a reject.
- R11: A reject whose source number is 0 or the IPI number 2 is never reported.
- R12: Strobes last one cycle. An offer that arrives together with a command is declined (R4 flag set) while the command proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 accept, 1 threshold write, 2 request-priority write, 3 end-of-interrupt |
| cmd_data | input | 32 | Command operand |
| eoi_src_active | input | 1 | Source named by an end-of-interrupt is still asserted |
| offer_valid | input | 1 | External interrupt offered this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rsp_valid | output | 1 | Accept response valid |
| rsp_data | output | 32 | Accept response word |
| reject_valid | output | 1 | Reject strobe |
| reject_src | output | 24 | Rejected source number |
| resend_valid | output | 1 | Resend request strobe |

## Verification
The bench builds the block with its defaults: 8-bit priorities, 24-bit source numbers and the IPI at number 2. With these values the whole 32-bit accept word is checked. The 0xFF sentinel can be reached both as a threshold and as an empty pending priority. The IPI number lies inside the source space, so the reject filter for it and for zero can be exercised. A chained vector sequence moves the block through each command and offer outcome, and directed cases cover an offer that collides with a command, an end-of-interrupt naming source zero, and a mid-run reset.

// File: rtl/irq_presenter_pkg.sv
// Shared definitions for the interrupt presenter.
// Assumes a 2-bit opcode field on the command port.
package irq_presenter_pkg;
    typedef enum logic [1:0] {
        OP_ACCEPT   = 2'd0,
        OP_SET_CPPR = 2'd1,
        OP_SET_MFRR = 2'd2,
        OP_EOI      = 2'd3
    } ipc_op_e;
endpackage

// File: rtl/ipc_cmd_unit.sv
// Next-state logic for the four processor commands.
// Purely combinational; assumes at most one command per cycle.
// Produces a raw reject candidate (unfiltered) and a resend request.
module ipc_cmd_unit
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic              cmd_valid,
    input  ipc_op_e           cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              src_active,
    input  logic [PRIO_W-1:0] cur_thr,
    input  logic [PRIO_W-1:0] cur_req,
    input  logic [SRC_W-1:0]  cur_src,
    input  logic [PRIO_W-1:0] cur_pri,
    input  logic              cur_flag,
    output logic [PRIO_W-1:0] nxt_thr,
    output logic [PRIO_W-1:0] nxt_req,
    output logic [SRC_W-1:0]  nxt_src,
    output logic [PRIO_W-1:0] nxt_pri,
    output logic              nxt_flag,
    output logic [SRC_W-1:0]  rej_src,
    output logic              resend_req,
    output logic              rsp_req,
    output logic [WORD_W-1:0] rsp_word
);
    localparam logic [PRIO_W-1:0] NONE_PRI = '1;
    localparam logic [SRC_W-1:0]  IPI_ID   = SRC_W'(IPI_SRC);

    logic [PRIO_W-1:0] low_val;
    logic [PRIO_W-1:0] lower_to;
    logic              lower_go;
    logic [SRC_W-1:0]  eoi_src;

    assign low_val = cmd_data[PRIO_W-1:0];
    assign eoi_src = cmd_data[SRC_W-1:0];

    // Evaluate the command against the current state.
    always_comb begin
        nxt_thr    = cur_thr;
        nxt_req    = cur_req;
        nxt_src    = cur_src;
        nxt_pri    = cur_pri;
        nxt_flag   = cur_flag;
        rej_src    = '0;
        resend_req = 1'b0;
        rsp_req    = 1'b0;
        rsp_word   = {cur_thr, cur_src};
        lower_go   = 1'b0;
        lower_to   = cur_thr;
        if (cmd_valid) begin
            case (cmd_op)
                OP_ACCEPT: begin
                    rsp_req = 1'b1;
                    if (cur_src != '0) begin
                        nxt_thr = cur_pri;
                        nxt_pri = NONE_PRI;
                        nxt_src = '0;
                    end
                end
                OP_SET_CPPR: begin
                    if (low_val > cur_thr) begin
                        lower_go = 1'b1;
                        lower_to = low_val;
                    end else if (low_val < cur_thr) begin
                        nxt_thr = low_val;
                        if (low_val <= cur_pri) begin
                            rej_src = cur_src;
                            nxt_src = '0;
                            nxt_pri = NONE_PRI;
                        end
                    end
                end
                OP_SET_MFRR: begin
                    nxt_req = low_val;
                    if (low_val < cur_thr && low_val <= cur_pri) begin
                        rej_src = cur_src;
                        nxt_pri = low_val;
                        nxt_src = IPI_ID;
                    end
                    if (low_val > cur_req && low_val > cur_thr) begin
                        resend_req = cur_flag;
                        nxt_flag   = 1'b0;
                    end
                end
                default: begin
                    lower_go = 1'b1;
                    lower_to = cmd_data[WORD_W-1:SRC_W];
                    if (eoi_src != IPI_ID && src_active)
                        rej_src = eoi_src;
                end
            endcase
            if (lower_go) begin
                nxt_thr = lower_to;
                if (cur_req < lower_to && cur_req <= cur_pri) begin
                    nxt_pri = cur_req;
                    nxt_src = IPI_ID;
                end
                resend_req = cur_flag;
                nxt_flag   = 1'b0;
            end
        end
    end
endmodule

// File: rtl/ipc_offer_unit.sv
// Decides whether an external offer replaces the pending source.
// Combinational; assumes offered source numbers are nonzero.
// An offer colliding with a command is always declined.
module ipc_offer_unit #(
    parameter int PRIO_W = 8,
    parameter int SRC_W  = 24
) (
    input  logic              offer_valid,
    input  logic              busy,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_pri,
    input  logic [PRIO_W-1:0] in_thr,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [PRIO_W-1:0] in_pri,
    input  logic              in_flag,
    output logic [SRC_W-1:0]  nxt_src,
    output logic [PRIO_W-1:0] nxt_pri,
    output logic              nxt_flag,
    output logic [SRC_W-1:0]  rej_src
);
    // Take or decline the offer.
    always_comb begin
        nxt_src  = in_src;
        nxt_pri  = in_pri;
        nxt_flag = in_flag;
        rej_src  = '0;
        if (offer_valid) begin
            if (!busy && offer_pri < in_thr && offer_pri < in_pri) begin
                rej_src = in_src;
                nxt_src = offer_src;
                nxt_pri = offer_pri;
            end else begin
                nxt_flag = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ipc_report.sv
// Registers the response word and the reject/resend strobes.
// Drops rejects of source 0 and of the IPI number.
module ipc_report #(
    parameter int SRC_W   = 24,
    parameter int WORD_W  = 32,
    parameter int IPI_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  rej_in,
    input  logic              resend_in,
    input  logic              rsp_in,
    input  logic [WORD_W-1:0] rsp_word_in,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              reject_valid,
    output logic [SRC_W-1:0]  reject_src,
    output logic              resend_valid
);
    localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

    logic rej_ok;
    assign rej_ok = (rej_in != '0) && (rej_in != IPI_ID);

    // One-cycle strobes and response capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
            reject_valid <= 1'b0;
            reject_src   <= '0;
            resend_valid <= 1'b0;
        end else begin
            rsp_valid    <= rsp_in;
            rsp_data     <= rsp_in ? rsp_word_in : '0;
            reject_valid <= rej_ok;
            reject_src   <= rej_ok ? rej_in : '0;
            resend_valid <= resend_in;
        end
    end
endmodule

// File: rtl/irq_presenter.sv
// Per-processor interrupt presenter: threshold, IPI request priority,
// one pending source with priority, and a declined-offer flag.
// Commands take precedence over offers in the same cycle.
module irq_presenter
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [WORD_W-1:0] cmd_data,
    input  logic              eoi_src_active,
    input  logic              offer_valid,
    input  logic [SRC_W-1:0]  offer_src,
    input  logic [PRIO_W-1:0] offer_prio,
    output logic              irq_out,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              reject_valid,
    output logic [SRC_W-1:0]  reject_src,
    output logic              resend_valid
);
    localparam logic [PRIO_W-1:0] NONE_PRI = '1;

    logic [PRIO_W-1:0] thr_q, req_q, pri_q;
    logic [SRC_W-1:0]  src_q;
    logic              flag_q;

    logic [PRIO_W-1:0] c_thr, c_req, c_pri, o_pri;
    logic [SRC_W-1:0]  c_src, o_src, c_rej, o_rej;
    logic              c_flag, o_flag, c_resend, c_rsp;
    logic [WORD_W-1:0] c_word;

    ipc_cmd_unit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) cmd_u (
        .cmd_valid (cmd_valid),
        .cmd_op    (ipc_op_e'(cmd_op)),
        .cmd_data  (cmd_data),
        .src_active(eoi_src_active),
        .cur_thr   (thr_q),
        .cur_req   (req_q),
        .cur_src   (src_q),
        .cur_pri   (pri_q),
        .cur_flag  (flag_q),
        .nxt_thr   (c_thr),
        .nxt_req   (c_req),
        .nxt_src   (c_src),
        .nxt_pri   (c_pri),
        .nxt_flag  (c_flag),
        .rej_src   (c_rej),
        .resend_req(c_resend),
        .rsp_req   (c_rsp),
        .rsp_word  (c_word)
    );

    ipc_offer_unit #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) offer_u (
        .offer_valid(offer_valid),
        .busy       (cmd_valid),
        .offer_src  (offer_src),
        .offer_pri  (offer_prio),
        .in_thr     (c_thr),
        .in_src     (c_src),
        .in_pri     (c_pri),
        .in_flag    (c_flag),
        .nxt_src    (o_src),
        .nxt_pri    (o_pri),
        .nxt_flag   (o_flag),
        .rej_src    (o_rej)
    );

    // Presenter state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q  <= '0;
            req_q  <= NONE_PRI;
            src_q  <= '0;
            pri_q  <= NONE_PRI;
            flag_q <= 1'b0;
        end else begin
            thr_q  <= c_thr;
            req_q  <= c_req;
            src_q  <= o_src;
            pri_q  <= o_pri;
            flag_q <= o_flag;
        end
    end

    // Interrupt line follows the stored state.
    assign irq_out = (src_q != '0) && (pri_q < thr_q);

    ipc_report #(.SRC_W(SRC_W), .WORD_W(WORD_W), .IPI_SRC(IPI_SRC)) rpt_u (
        .clk         (clk),
        .rst_n       (rst_n),
        .rej_in      (cmd_valid ? c_rej : o_rej),
        .resend_in   (c_resend),
        .rsp_in      (c_rsp),
        .rsp_word_in (c_word),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .reject_valid(reject_valid),
        .reject_src  (reject_src),
        .resend_valid(resend_valid)
    );
endmodule

// File: rtl/irq_presenter_chk.sv
// Port-level property checker for the interrupt presenter, bound below.
module irq_presenter_chk
    import irq_presenter_pkg::*;
#(
    parameter int PRIO_W  = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2,
    localparam int WORD_W = PRIO_W + SRC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic [WORD_W-1:0] cmd_data,
    input logic              eoi_src_active,
    input logic              offer_valid,
    input logic [SRC_W-1:0]  offer_src,
    input logic [PRIO_W-1:0] offer_prio,
    input logic              irq_out,
    input logic              rsp_valid,
    input logic [WORD_W-1:0] rsp_data,
    input logic              reject_valid,
    input logic [SRC_W-1:0]  reject_src,
    input logic              resend_valid
);
    localparam logic [SRC_W-1:0] IPI_ID = SRC_W'(IPI_SRC);

    // R2
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_out && !rsp_valid && !reject_valid && !resend_valid));

    // R11
    reject_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> (reject_src != '0 && reject_src != IPI_ID));

    // R3
    rsp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_op == OP_ACCEPT));

    // R3
    accept_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data[SRC_W-1:0] != '0) |-> !irq_out);

    // R12
    resend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resend_valid |-> $past(cmd_valid && cmd_op != OP_ACCEPT));

    // R12
    reject_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject_valid |-> $past(cmd_valid || offer_valid));

    // R1
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(cmd_valid || offer_valid));
endmodule

bind irq_presenter irq_presenter_chk #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) chk_i (.*);

// File: tb/irq_presenter_tb.sv
module irq_presenter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [31:0] cmd_data = '0;
    logic        eoi_src_active = 1'b0;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_prio = '0;
    logic        irq_out, rsp_valid, reject_valid, resend_valid;
    logic [31:0] rsp_data;
    logic [23:0] reject_src;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_presenter dut_i (.*);

    typedef struct packed {
        logic        is_offer;
        logic [1:0]  op;
        logic [31:0] data;
        logic        act;
        logic [23:0] src;
        logic [7:0]  pri;
        logic        e_irq;
        logic        e_rjv;
        logic [23:0] e_rj;
        logic        e_rs;
        logic        e_rspv;
        logic [31:0] e_rsp;
    } vec_t;

    // op: 0 accept, 1 threshold, 2 request priority, 3 end-of-interrupt
    localparam vec_t VECS [0:22] = '{
        '{1'b0, 2'd1, 32'h000000FF, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},        // R8 lower
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h100, 8'h10, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R4 take
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h200, 8'h20, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R4 decline
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h300, 8'h05, 1'b1, 1'b1, 24'h100, 1'b0, 1'b0, 32'h0},            // R4 displace
        '{1'b0, 2'd0, 32'h0, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'hFF000300},         // R3
        '{1'b0, 2'd0, 32'h0, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h05000000},         // R3 empty
        '{1'b0, 2'd3, 32'hFF000300, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0},         // R10 inactive
        '{1'b0, 2'd2, 32'h00000040, 1'b0, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},         // R5
        '{1'b0, 2'd1, 32'h00000030, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},         // R7 R11 IPI
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h400, 8'h30, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R4 equal
        '{1'b0, 2'd1, 32'h00000050, 1'b0, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0},         // R8 IPI
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h500, 8'h20, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R11 IPI displaced
        '{1'b0, 2'd2, 32'h00000010, 1'b0, 24'h0, 8'h00, 1'b1, 1'b1, 24'h500, 1'b0, 1'b0, 32'h0},       // R5 reject
        '{1'b0, 2'd2, 32'h00000060, 1'b0, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},         // R6 flag clear
        '{1'b0, 2'd0, 32'h0, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h50000002},         // R3 IPI
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h600, 8'h08, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R4
        '{1'b0, 2'd3, 32'h50000002, 1'b1, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},         // R10 IPI
        '{1'b0, 2'd1, 32'h00000050, 1'b0, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},         // R9
        '{1'b1, 2'd0, 32'h0, 1'b0, 24'h700, 8'h70, 1'b1, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0},              // R4 decline
        '{1'b0, 2'd2, 32'h00000070, 1'b0, 24'h0, 8'h00, 1'b1, 1'b0, 24'h0, 1'b1, 1'b0, 32'h0},         // R6
        '{1'b0, 2'd0, 32'h0, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b1, 32'h50000600},         // R3
        '{1'b0, 2'd3, 32'h50000700, 1'b1, 24'h0, 8'h00, 1'b0, 1'b1, 24'h700, 1'b0, 1'b0, 32'h0},       // R10
        '{1'b0, 2'd1, 32'h00000000, 1'b0, 24'h0, 8'h00, 1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 32'h0}          // R7 R11 zero
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 1'b0; offer_valid = 1'b0; eoi_src_active = 1'b0;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [31:0] d, input logic a);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; eoi_src_active = a;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: state while and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 irq_out", {31'b0, irq_out}, 32'd0);
        check("R2 strobes", {29'b0, rsp_valid, reject_valid, resend_valid}, 32'd0);

        foreach (VECS[i]) begin
            if (VECS[i].is_offer) begin
                offer_valid = 1'b1; offer_src = VECS[i].src; offer_prio = VECS[i].pri;
            end else begin
                send_cmd(VECS[i].op, VECS[i].data, VECS[i].act);
            end
            @(negedge clk);
            idle();
            check($sformatf("R1 irq_out v%0d", i), {31'b0, irq_out}, {31'b0, VECS[i].e_irq});
            check($sformatf("R11 reject_valid v%0d", i), {31'b0, reject_valid}, {31'b0, VECS[i].e_rjv});
            if (VECS[i].e_rjv)
                check($sformatf("R5 R7 R10 reject_src v%0d", i), {8'b0, reject_src}, {8'b0, VECS[i].e_rj});
            check($sformatf("R6 R8 resend v%0d", i), {31'b0, resend_valid}, {31'b0, VECS[i].e_rs});
            check($sformatf("R3 rsp_valid v%0d", i), {31'b0, rsp_valid}, {31'b0, VECS[i].e_rspv});
            if (VECS[i].e_rspv)
                check($sformatf("R3 rsp_data v%0d", i), rsp_data, VECS[i].e_rsp);
        end

        // R12: one-cycle strobe, then silence
        @(negedge clk);
        check("R12 strobe width", {30'b0, reject_valid, resend_valid}, 32'd0);

        // R12: offer with a command is declined; flag shows up on the next lowering
        send_cmd(2'd1, 32'h000000FF, 1'b0);
        offer_valid = 1'b1; offer_src = 24'h800; offer_prio = 8'h10;
        @(negedge clk); idle();
        check("R12 no resend yet", {31'b0, resend_valid}, 32'd0);
        send_cmd(2'd0, 32'h0, 1'b0);
        @(negedge clk); idle();
        check("R12 accept shows IPI not offer", rsp_data, 32'hFF000002);
        send_cmd(2'd1, 32'h000000FF, 1'b0);
        @(negedge clk); idle();
        check("R12 declined flag resent", {31'b0, resend_valid}, 32'd1);

        // R11: end-of-interrupt naming source 0 is not reported
        send_cmd(2'd3, 32'hFF000000, 1'b1);
        @(negedge clk); idle();
        check("R11 zero source", {31'b0, reject_valid}, 32'd0);

        // R2: mid-run reset restores empty state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 irq after reset", {31'b0, irq_out}, 32'd0);
        send_cmd(2'd0, 32'h0, 1'b0);
        @(negedge clk); idle();
        check("R2 accept after reset", rsp_data, 32'h00000000);
        check("R2 accept valid", {31'b0, rsp_valid}, 32'd1);

        finish_run();
    end
endmodule